// File: doc/BRIEF.md
# Serial Flash Read Command Front End

This block is the slave side of a four-wire serial link that behaves like a small serial flash. It samples the serial clock, select and data-in pins with the system clock. It assembles 8-bit bus cycles and decodes the opcode in the first one. It then serves four kinds of read: plain array read, array read with one dummy byte, identification read and status read. Reads stream byte after byte for as long as the select stays low.

The readable array is 2^ADDR_W bytes; the default is 17 address bits, which is 128 KByte. Its contents are computed from the address, so a host can check any read without a preload. Any opcode that changes state (enables, protection, program, erase) is not acted on here. Each complete byte of such a command is passed on a pulse interface to a separate protection and status unit, and that unit returns the current status byte.

Top module: `spi_flash_front`

## Requirements
- R1: Data-in is captured on each rising serial-clock edge, most significant bit first, with the clock idling either low or high between selections. Data-out changes only after falling serial-clock edges and holds steady across the rising edge that the host samples on.
- R2: Opcode 03h followed by three address bytes streams array bytes from that address upward, one byte per bus cycle. The byte at address a is formed in three steps: XOR-fold a into 8 bits (address bit i lands on bit i mod 8), rotate the result left by 3, then XOR with 96h.
- R3: After the highest array address (1FFFFh by default) the stream continues from address 0.
- R4: Address bits at and above ADDR_W (bits 23..17 by default) do not affect which byte is returned.
- R5: Opcode 0Bh takes three address bytes and one ignored dummy byte, then streams the same bytes as R2.
- R6: Opcodes 90h and ABh take three address bytes; the output then alternates between BFh and 49h, starting with BFh when bit 0 of the third address byte is 0 and with 49h when it is 1.
- R7: Opcode 05h returns the status input byte in every following bus cycle until deselect.
- R8: Raising the select mid-byte discards the partial byte, forwards nothing for it and returns to opcode reception for the next selection.
- R9: An opcode that is neither a read nor a write-type code is ignored until deselect, with the output driver off.
- R10: The output enable is low while deselected and during every opcode, address and dummy byte. It is high during each streamed output byte.
- R11: Write-type opcodes (01h, 02h, 04h, 06h, 20h, 50h, 52h, 60h, AFh, C7h, D8h) and each later complete byte of the same selection are forwarded as one-clock pulses, with the first flag set only on the opcode. Read opcodes forward nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock pin, asynchronous |
| cs_n_i | input | 1 | Active-low select pin, asynchronous |
| si_i | input | 1 | Serial data-in pin, asynchronous |
| status_i | input | 8 | Status byte from the protection unit |
| so_o | output | 1 | Serial data-out, 0 when not enabled |
| so_oe_o | output | 1 | Output enable for the data-out pad |
| fwd_valid_o | output | 1 | Pulse: a write-type byte is forwarded |
| fwd_first_o | output | 1 | Forwarded byte is the opcode |
| fwd_byte_o | output | 8 | Forwarded byte value |

## Verification
Pin changes pass through a two-stage synchroniser and an edge register, so data-out and its enable move three system clocks after a falling serial-clock edge. The bench keeps each serial-clock half period at six system clocks. It samples data-out just before raising the clock and again halfway through the high phase. Forwarded pulses appear one clock after the byte-completing edge is detected; a monitor logs them, and the bench reads the log only after deselect plus several idle clocks. Enable checks taken after deselect wait four half periods, well past the three-clock pipeline.

// File: rtl/spi_fe_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and opcode decode for the serial flash front end.
// Assumes 8-bit bus cycles throughout.
package spi_fe_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [7:0] OP_READ      = 8'h03;
    localparam logic [7:0] OP_FAST_READ = 8'h0B;
    localparam logic [7:0] OP_IDENT_A   = 8'h90;
    localparam logic [7:0] OP_IDENT_B   = 8'hAB;
    localparam logic [7:0] OP_STATUS    = 8'h05;

    typedef enum logic [3:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_ARRAY_OUT,
        ST_ID_OUT,
        ST_STAT_OUT,
        ST_FORWARD,
        ST_DISCARD
    } fe_state_t;

    typedef enum logic [1:0] {
        K_PLAIN,
        K_FAST,
        K_IDENT
    } addr_kind_t;

    // True for opcodes handled by the external protection/status unit.
    function automatic logic is_write_op(input logic [7:0] op);
        case (op)
            8'h01, 8'h02, 8'h04, 8'h06, 8'h20, 8'h50,
            8'h52, 8'h60, 8'hAF, 8'hC7, 8'hD8: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes each pin is independent (no multi-bit coherence needed) and
// STAGES >= 2.
module spi_fe_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the pin values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_fe_shift.sv
`timescale 1ns/1ps
// Input deserialiser: counts serial-clock rising edges inside a selection
// and emits each completed byte with a one-clock done pulse.
// Assumes rise_i is already a single-cycle pulse in the system clock domain.
module spi_fe_shift
    import spi_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              rise_i,
    input  logic              bit_i,
    output logic [CNT_W-1:0]  bit_idx_o,
    output logic              done_o,
    output logic [BYTE_W-1:0] byte_o
);

    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] next_shreg;

    assign next_shreg = {shreg_q[BYTE_W-2:0], bit_i};

    // Collect bits MSB first; restart whenever the selection drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_idx_o <= '0;
            done_o    <= 1'b0;
            byte_o    <= '0;
        end else if (!active_i) begin
            shreg_q   <= '0;
            bit_idx_o <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (rise_i) begin
                shreg_q   <= next_shreg;
                bit_idx_o <= bit_idx_o + 1'b1;
                if (bit_idx_o == CNT_W'(BYTE_W - 1)) begin
                    done_o <= 1'b1;
                    byte_o <= next_shreg;
                end
            end
        end
    end

    AST_DONE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (bit_idx_o == '0)) else $error("byte done off boundary"); // R1

endmodule

// File: rtl/spi_fe_pattern.sv
`timescale 1ns/1ps
// Read-only array whose byte at each address is computed from the address:
// fold the address bits onto 8 bits, rotate left by 3, XOR with 96h.
// Purely combinational; assumes ADDR_W >= 9.
module spi_fe_pattern #(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        data_o
);

    logic [7:0] fold;

    // Compute the stored byte for the requested address.
    always_comb begin
        fold = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            fold[i % 8] = fold[i % 8] ^ addr_i[i];
        end
        data_o = {fold[4:0], fold[7:5]} ^ 8'h96;
    end

endmodule

// File: rtl/spi_flash_front.sv
`timescale 1ns/1ps
// Serial flash command front end. Oversamples the serial pins with the
// system clock, decodes the opcode, gathers address bytes and streams
// array, identification or status bytes. Write-type commands are
// forwarded byte by byte to an external protection/status unit.
// Assumes each serial-clock half period spans at least five system clocks.
module spi_flash_front
    import spi_fe_pkg::*;
#(
    parameter int         ADDR_W      = 17,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ID_EVEN     = 8'hBF,
    parameter logic [7:0] ID_ODD      = 8'h49
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       cs_n_i,
    input  logic       si_i,
    input  logic [7:0] status_i,
    output logic       so_o,
    output logic       so_oe_o,
    output logic       fwd_valid_o,
    output logic       fwd_first_o,
    output logic [7:0] fwd_byte_o
);

    localparam int              HI_W    = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

    logic              cs_s, sck_s, si_s, sck_d;
    logic              sck_rise, sck_fall;
    logic [CNT_W-1:0]  bit_idx;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    fe_state_t         state;
    addr_kind_t        kind;
    logic [1:0]        addr_cnt;
    logic [HI_W-1:0]   addr_hi;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] look_addr;
    logic [7:0]        pat_data;
    logic              id_sel;
    logic [7:0]        out_byte;
    logic              so_q, oe_q;
    logic              out_state;

    spi_fe_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({cs_n_i, sck_i, si_i}),
        .q_o  ({cs_s, sck_s, si_s})
    );

    // Remember the previous synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign sck_rise = !cs_s &&  sck_s && !sck_d;
    assign sck_fall = !cs_s && !sck_s &&  sck_d;

    spi_fe_shift i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (!cs_s),
        .rise_i   (sck_rise),
        .bit_i    (si_s),
        .bit_idx_o(bit_idx),
        .done_o   (byte_done),
        .byte_o   (byte_val)
    );

    // Final address byte looks up its own address; streaming uses the pointer.
    assign look_addr = (state == ST_ADDR) ? {addr_hi, byte_val} : ptr;

    spi_fe_pattern #(.ADDR_W(ADDR_W)) i_array (
        .addr_i(look_addr),
        .data_o(pat_data)
    );

    assign out_state = (state == ST_ARRAY_OUT) || (state == ST_ID_OUT) ||
                       (state == ST_STAT_OUT);

    // Command sequencer: decode, address capture, output byte preparation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_OPCODE;
            kind        <= K_PLAIN;
            addr_cnt    <= '0;
            addr_hi     <= '0;
            ptr         <= '0;
            id_sel      <= 1'b0;
            out_byte    <= '0;
            fwd_valid_o <= 1'b0;
            fwd_first_o <= 1'b0;
            fwd_byte_o  <= '0;
        end else if (cs_s) begin
            state       <= ST_OPCODE;
            addr_cnt    <= '0;
            fwd_valid_o <= 1'b0;
            fwd_first_o <= 1'b0;
        end else begin
            fwd_valid_o <= 1'b0;
            fwd_first_o <= 1'b0;
            if (byte_done) begin
                unique case (state)
                    ST_OPCODE: begin
                        if (byte_val == OP_READ) begin
                            kind  <= K_PLAIN;
                            state <= ST_ADDR;
                        end else if (byte_val == OP_FAST_READ) begin
                            kind  <= K_FAST;
                            state <= ST_ADDR;
                        end else if (byte_val == OP_IDENT_A || byte_val == OP_IDENT_B) begin
                            kind  <= K_IDENT;
                            state <= ST_ADDR;
                        end else if (byte_val == OP_STATUS) begin
                            out_byte <= status_i;
                            state    <= ST_STAT_OUT;
                        end else if (is_write_op(byte_val)) begin
                            fwd_valid_o <= 1'b1;
                            fwd_first_o <= 1'b1;
                            fwd_byte_o  <= byte_val;
                            state       <= ST_FORWARD;
                        end else begin
                            state <= ST_DISCARD;
                        end
                    end
                    ST_ADDR: begin
                        addr_hi  <= HI_W'({addr_hi, byte_val});
                        addr_cnt <= addr_cnt + 1'b1;
                        if (addr_cnt == 2'd2) begin
                            unique case (kind)
                                K_PLAIN: begin
                                    out_byte <= pat_data;
                                    ptr      <= look_addr + PTR_ONE;
                                    state    <= ST_ARRAY_OUT;
                                end
                                K_FAST: begin
                                    ptr   <= look_addr;
                                    state <= ST_DUMMY;
                                end
                                default: begin
                                    out_byte <= byte_val[0] ? ID_ODD : ID_EVEN;
                                    id_sel   <= !byte_val[0];
                                    state    <= ST_ID_OUT;
                                end
                            endcase
                        end
                    end
                    ST_DUMMY, ST_ARRAY_OUT: begin
                        out_byte <= pat_data;
                        ptr      <= ptr + PTR_ONE;
                        state    <= ST_ARRAY_OUT;
                    end
                    ST_ID_OUT: begin
                        out_byte <= id_sel ? ID_ODD : ID_EVEN;
                        id_sel   <= !id_sel;
                    end
                    ST_STAT_OUT: begin
                        out_byte <= status_i;
                    end
                    ST_FORWARD: begin
                        fwd_valid_o <= 1'b1;
                        fwd_byte_o  <= byte_val;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // Output shifter: present the next bit after each falling clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            so_q <= 1'b0;
            oe_q <= 1'b0;
        end else if (sck_fall && out_state) begin
            so_q <= out_byte[~bit_idx];
            oe_q <= 1'b1;
        end
    end

    assign so_o    = oe_q ? so_q : 1'b0;
    assign so_oe_o = oe_q;

    AST_SO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !$past(cs_s) && !$past(sck_fall)) |-> $stable(so_q)) else $error("so moved without falling edge"); // R1

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !$past(cs_s) && $past(byte_done) && $past(state) == ST_ARRAY_OUT)
        |-> (ptr == $past(ptr) + PTR_ONE)) else $error("pointer did not step"); // R3

    AST_ID_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !$past(cs_s) && $past(byte_done) && $past(state) == ST_ID_OUT)
        |-> (out_byte != $past(out_byte))) else $error("ID did not alternate"); // R6

    AST_ABORT_TO_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_s) |=> (state == ST_OPCODE && !oe_q && !fwd_valid_o)) else $error("deselect did not abort"); // R8

    AST_OE_OUTPUT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> (out_state && !$past(cs_s))) else $error("output enabled outside output phase"); // R10

    AST_FWD_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid_o |-> $past(byte_done)) else $error("forward without complete byte"); // R11

endmodule

// File: tb/test_spi_flash_front.sv
`timescale 1ns/1ps
module test_spi_flash_front;

    localparam int CLK_NS  = 10;
    localparam int HALF_NS = 6 * CLK_NS;
    localparam int AW      = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       si = 1'b0;
    logic [7:0] status = 8'h00;
    logic       so, so_oe, fwd_valid, fwd_first;
    logic [7:0] fwd_byte;

    int checks = 0;
    int errors = 0;
    bit mode3  = 1'b0;
    bit ended  = 1'b0;
    logic [8:0] fwd_log [0:31];
    int fwd_n = 0;

    always #(CLK_NS/2) clk = ~clk;

    spi_flash_front i_spi_flash_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck),
        .cs_n_i     (cs_n),
        .si_i       (si),
        .status_i   (status),
        .so_o       (so),
        .so_oe_o    (so_oe),
        .fwd_valid_o(fwd_valid),
        .fwd_first_o(fwd_first),
        .fwd_byte_o (fwd_byte)
    );

    // Log every forwarded byte.
    always @(posedge clk) begin
        if (rst_n && fwd_valid) begin
            if (fwd_n < 32) fwd_log[fwd_n] <= {fwd_first, fwd_byte};
            fwd_n <= fwd_n + 1;
        end
    end

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        logic [7:0] f = '0;
        for (int i = 0; i < AW; i++) f[i % 8] = f[i % 8] ^ a[i];
        return {f[4:0], f[7:5]} ^ 8'h96;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] din, output logic [7:0] dout,
                        output bit oe_all, output bit oe_any, output bit steady);
        oe_all = 1'b1; oe_any = 1'b0; steady = 1'b1; dout = '0;
        for (int b = 7; b >= 0; b--) begin
            sck = 1'b0; si = din[b];
            #(HALF_NS);
            dout[b] = so; oe_all &= so_oe; oe_any |= so_oe;
            sck = 1'b1;
            #(HALF_NS/2);
            if (so !== dout[b]) steady = 1'b0;
            #(HALF_NS/2);
        end
    endtask

    task automatic xfer_bits(input logic [7:0] din, input int nbits);
        for (int b = 7; b > 7 - nbits; b--) begin
            sck = 1'b0; si = din[b]; #(HALF_NS);
            sck = 1'b1; #(HALF_NS);
        end
    endtask

    task automatic begin_tx();
        sck = mode3; #(HALF_NS);
        cs_n = 1'b0; #(HALF_NS);
    endtask

    task automatic end_tx();
        if (!mode3) begin sck = 1'b0; #(HALF_NS); end
        cs_n = 1'b1;
        #(4*HALF_NS);
        chk(so_oe == 1'b0, "R10 oe after deselect", so_oe, 0);
    endtask

    task automatic send_in(input logic [7:0] b, input string req);
        logic [7:0] d; bit all, any, st;
        xfer(b, d, all, any, st);
        chk(!any, req, any, 0);
    endtask

    task automatic do_read(input logic [7:0] op, input logic [23:0] a, input int n,
                           input string req);
        logic [7:0] d, e; bit all, any, st, st_all;
        logic [AW-1:0] ea;
        st_all = 1'b1;
        begin_tx();
        send_in(op, "R10 oe in opcode");
        for (int k = 0; k < 3; k++) send_in(a[23-8*k -: 8], "R10 oe in address");
        if (op == 8'h0B) send_in(8'h5A, "R5 oe in dummy");
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, d, all, any, st);
            st_all &= st;
            ea = a[AW-1:0] + AW'(i);
            e  = pat(ea);
            chk(d == e && all, req, {23'h0, all, d}, {24'h1, e});
        end
        chk(st_all, "R1 so steady over rising edge", st_all, 1);
        end_tx();
    endtask

    task automatic do_ident(input logic [7:0] op, input logic [7:0] ida, input int n);
        logic [7:0] d, e; bit all, any, st;
        begin_tx();
        send_in(op, "R10 oe in opcode");
        send_in(8'h00, "R10"); send_in(8'h00, "R10"); send_in(ida, "R10");
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, d, all, any, st);
            e = ((ida[0] ^ i[0]) != 1'b0) ? 8'h49 : 8'hBF;
            chk(d == e && all, "R6 ID byte", d, e);
        end
        end_tx();
    endtask

    initial begin
        logic [7:0] d; bit all, any, st;
        int base;
        void'($urandom(32'h5EED1234));
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        #2;
        rst_n = 1'b1;
        #(4*CLK_NS);
        chk(so_oe == 1'b0 && fwd_valid == 1'b0, "R10 reset state", {so_oe, fwd_valid}, 0);

        // Directed reads, both clock idle levels
        mode3 = 1'b0; do_read(8'h03, 24'h000010, 4, "R2 read mode0");
        mode3 = 1'b1; do_read(8'h03, 24'h000010, 3, "R1 R2 read mode3");
        mode3 = 1'b1; do_read(8'h03, 24'h01FFFE, 4, "R3 wrap");
        mode3 = 1'b0; do_read(8'h03, 24'hFE0010, 2, "R4 upper bits ignored");
        mode3 = 1'b0; do_read(8'h0B, 24'h00ABCD, 3, "R5 fast read");
        mode3 = 1'b1; do_read(8'h0B, 24'h01FFFF, 2, "R3 R5 fast read wrap");

        // Random reads
        for (int r = 0; r < 12; r++) begin
            mode3 = $urandom_range(1, 0) != 0;
            do_read(($urandom_range(1, 0) != 0) ? 8'h0B : 8'h03,
                    24'($urandom), $urandom_range(5, 1), "R2 random read");
        end

        // Identification
        mode3 = 1'b0; do_ident(8'h90, 8'h00, 4);
        mode3 = 1'b1; do_ident(8'hAB, 8'h01, 3);

        // Status repeated
        for (int r = 0; r < 2; r++) begin
            status = 8'($urandom);
            mode3 = r[0];
            begin_tx();
            send_in(8'h05, "R10 oe in opcode");
            for (int i = 0; i < 3; i++) begin
                xfer(8'h00, d, all, any, st);
                chk(d == status && all, "R7 status byte", d, status);
            end
            end_tx();
        end

        // Unknown opcode
        mode3 = 1'b0;
        base = fwd_n;
        begin_tx();
        send_in(8'h3C, "R9 unknown opcode");
        for (int i = 0; i < 3; i++) send_in(8'($urandom), "R9 unknown opcode stays off");
        end_tx();
        chk(fwd_n == base, "R9 unknown not forwarded", fwd_n - base, 0);

        // Abort mid address, then a clean read
        begin_tx();
        send_in(8'h03, "R10"); send_in(8'h00, "R10");
        xfer_bits(8'hFF, 3);
        end_tx();
        do_read(8'h03, 24'h000020, 2, "R8 read after abort");
        base = fwd_n;
        begin_tx();
        xfer_bits(8'h06, 5);
        end_tx();
        chk(fwd_n == base, "R8 partial opcode not forwarded", fwd_n - base, 0);

        // Write-type forwarding
        base = fwd_n;
        begin_tx();
        send_in(8'h02, "R10"); send_in(8'h01, "R10"); send_in(8'h23, "R10");
        send_in(8'h45, "R10"); send_in(8'hA5, "R10");
        end_tx();
        chk(fwd_n - base == 5, "R11 forward count", fwd_n - base, 5);
        chk(fwd_log[base] == 9'h102, "R11 opcode flagged first", fwd_log[base], 9'h102);
        chk(fwd_log[base+1] == 9'h001 && fwd_log[base+4] == 9'h0A5, "R11 data bytes",
            {fwd_log[base+1], fwd_log[base+4]}, {9'h001, 9'h0A5});
        base = fwd_n;
        mode3 = 1'b1;
        begin_tx(); send_in(8'h06, "R10"); end_tx();
        chk(fwd_n - base == 1 && fwd_log[base] == 9'h106, "R11 lone enable opcode",
            fwd_log[base], 9'h106);
        base = fwd_n;
        do_read(8'h03, 24'h000100, 1, "R2 read");
        chk(fwd_n == base, "R11 read not forwarded", fwd_n - base, 0);

        ended = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        if (!ended) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule